// File: doc/BRIEF.md
# Parallel Sequential Prefetch Ways with Recency-Based Reallocation

This block sits below a first-level data cache and holds four independent sequential prefetch streams. Each stream (a "way") is a small circular queue of consecutive 16-byte lines. The line at the front of the queue is its head. Every miss address from the cache is compared against the head line of each way. On a match whose data has already arrived, the line goes back to the cache on the next cycle. That way then drops its head and fetches one more line further along its sequence. Because the ways run side by side, several interleaved array walks can each be followed at the same time.

A miss that matches no head takes over one way. An empty way is used first. If every way is busy, the way that has gone longest without a hit or a new assignment is taken. The chosen way is cleared, and it starts fetching the lines that follow the missed line. All ways share one request port to the next memory level through a rotating arbiter. Each request carries the way number and queue slot, so its response returns to the slot that asked for it. A response that arrives after its way was taken over is discarded.

Top module: `seqbuf_multiway`

## Requirements
- R1: After reset all ways are empty: supply_valid and mreq_valid stay low until a miss arrives.
- R2: A miss whose line address (miss_addr bits 31..4) equals an active way's head line, with that head's data returned, raises supply_valid with the head's data in the cycle after the miss. The four offset bits are ignored.
- R3: After a hit, the way's head moves to the next line, and the way keeps supplying consecutive lines past its queue depth.
- R4: A miss that matches no head takes the lowest-numbered empty way, or the least recently used way if none is empty. That way then holds the lines following the missed line, and the stream it held before stops hitting.
- R5: Recency is refreshed by both a hit and a takeover, and the touched way becomes most recently used.
- R6: A miss that matches a head whose data has not yet returned produces no supply and takes over no way. The same line hits once its data arrives.
- R7: If several heads match, the lowest-numbered way serves the miss and every other matching way is emptied.
- R8: Requests from the ways are served in rotating order, one per accepted cycle. mreq_tag carries the way number in bits 3..2 and the slot number in bits 1..0, and mreq_addr is aligned to a line.
- R9: A response whose way was taken over after the request left is discarded, and that slot is then fetched again for the new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| supply_valid | output | 1 | Line supplied to the cache, one cycle after a hitting miss |
| supply_data | output | 128 | Supplied line data |
| mreq_valid | output | 1 | Prefetch request to the next level |
| mreq_ready | input | 1 | Next level accepts the request this cycle |
| mreq_addr | output | 32 | Line-aligned request address |
| mreq_tag | output | 4 | Way number and slot number of the request |
| mrsp_valid | input | 1 | Response from the next level |
| mrsp_tag | input | 4 | Tag of the request being answered |
| mrsp_data | input | 128 | Returned line data |

## Verification
The main function is driven by a miss sequence in which four streams interleave. The sequence then forces takeovers and tries the displaced streams again. It tells a correct least-recently-used victim apart from an oldest-first or lowest-first one, because each wrong choice leaves a different stream able to hit. A single long walk over ten lines separates correct head advance and refill from a queue that stalls at its depth. A miss with a nonzero offset shows that only the line bits are compared. Directed runs cover the following:
- Misses issued back to back, which fix the rotating grant order and the tag layout.
- A takeover while a response is still in flight, which tells a discarded response apart from one written into the new stream.
- A miss on a head that is still pending.
- Two ways that reach the same head, which shows whether the losing way was emptied.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;

    // Life cycle of one queue slot inside a way.
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,  // needs a fetch for its line
        SLOT_PEND  = 2'd1,  // fetch outstanding for the current stream
        SLOT_READY = 2'd2,  // data present
        SLOT_STALE = 2'd3   // fetch outstanding for a stream that was dropped
    } slot_state_e;

    // Circular index helper shared by the ways and the arbiter.
    function automatic int wrap_idx(input int base, input int off, input int n);
        return (base + off) % n;
    endfunction

endpackage

// File: rtl/seqbuf_way.sv
module seqbuf_way
    import seqbuf_pkg::*;
#(
    parameter int LA_W   = 28,
    parameter int DATA_W = 128,
    parameter int DEPTH  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_i,
    input  logic [LA_W-1:0]   alloc_line_i,
    input  logic              flush_i,
    input  logic              adv_i,
    input  logic              grant_i,
    input  logic              rsp_valid_i,
    input  logic [SLOT_W-1:0] rsp_slot_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              active_o,
    output logic [LA_W-1:0]   head_line_o,
    output logic              head_ready_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic              req_valid_o,
    output logic [LA_W-1:0]   req_line_o,
    output logic [SLOT_W-1:0] req_slot_o
);

    slot_state_e       st_q [DEPTH];
    slot_state_e       st_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [SLOT_W-1:0] head_ptr_q;
    logic [LA_W-1:0]   head_line_q;
    logic              active_q;

    // Oldest slot, counted from the head, that still needs a fetch.
    always_comb begin
        req_valid_o = 1'b0;
        req_slot_o  = '0;
        req_line_o  = head_line_q;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            int idx;
            idx = wrap_idx(int'(head_ptr_q), k, DEPTH);
            if (active_q && st_q[idx] == SLOT_IDLE) begin
                req_valid_o = 1'b1;
                req_slot_o  = SLOT_W'(idx);
                req_line_o  = head_line_q + LA_W'(k);
            end
        end
    end

    // Slot state update: response, then grant, then head/stream changes.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) st_d[i] = st_q[i];
        if (rsp_valid_i) begin
            if (st_q[rsp_slot_i] == SLOT_PEND)       st_d[rsp_slot_i] = SLOT_READY;
            else if (st_q[rsp_slot_i] == SLOT_STALE) st_d[rsp_slot_i] = SLOT_IDLE;
        end
        if (grant_i) st_d[req_slot_o] = SLOT_PEND;
        if (adv_i)   st_d[head_ptr_q] = SLOT_IDLE;
        if (alloc_i || flush_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_d[i] == SLOT_PEND)       st_d[i] = SLOT_STALE;
                else if (st_d[i] == SLOT_READY) st_d[i] = SLOT_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]   <= SLOT_IDLE;
                data_q[i] <= '0;
            end
            head_ptr_q  <= '0;
            head_line_q <= '0;
            active_q    <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= st_d[i];
            if (rsp_valid_i && st_q[rsp_slot_i] == SLOT_PEND)
                data_q[rsp_slot_i] <= rsp_data_i;
            if (alloc_i) begin
                head_line_q <= alloc_line_i;
                head_ptr_q  <= '0;
                active_q    <= 1'b1;
            end else if (flush_i) begin
                active_q    <= 1'b0;
            end else if (adv_i) begin
                head_ptr_q  <= head_ptr_q + 1'b1;
                head_line_q <= head_line_q + 1'b1;
            end
        end
    end

    assign active_o     = active_q;
    assign head_line_o  = head_line_q;
    assign head_ready_o = active_q && (st_q[head_ptr_q] == SLOT_READY);
    assign head_data_o  = data_q[head_ptr_q];

endmodule

// File: rtl/seqbuf_rr_arb.sv
module seqbuf_rr_arb
    import seqbuf_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req_i,
    input  logic             accept_i,
    output logic [N-1:0]     gnt_o,
    output logic [IDX_W-1:0] pick_o,
    output logic             any_o
);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        pick_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = wrap_idx(int'(ptr_q), k, N);
            if (req_i[idx]) pick_o = IDX_W'(idx);
        end
        any_o = |req_i;
        gnt_o = '0;
        if (any_o && accept_i) gnt_o[pick_o] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                  ptr_q <= '0;
        else if (any_o && accept_i) ptr_q <= IDX_W'(wrap_idx(int'(pick_o), 1, N));
    end

endmodule

// File: rtl/seqbuf_lru.sv
module seqbuf_lru #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output logic [IDX_W-1:0] victim_o
);

    // age 0 = most recent, N-1 = least recent
    logic [IDX_W-1:0] age_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(N - 1 - i);
        end else if (touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx_i)        age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_o = '0;
        for (int i = 0; i < N; i++)
            if (age_q[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
    end

endmodule

// File: rtl/seqbuf_multiway.sv
module seqbuf_multiway
    import seqbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NWAYS      = 4,
    parameter int DEPTH      = 4,
    parameter int DATA_W     = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFF_W,
    localparam int WAY_W     = $clog2(NWAYS),
    localparam int SLOT_W    = $clog2(DEPTH),
    localparam int TAG_W     = WAY_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              supply_valid,
    output logic [DATA_W-1:0] supply_data,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [TAG_W-1:0]  mreq_tag,
    input  logic              mrsp_valid,
    input  logic [TAG_W-1:0]  mrsp_tag,
    input  logic [DATA_W-1:0] mrsp_data
);

    logic [LA_W-1:0]   miss_line;
    logic [NWAYS-1:0]  active, head_ready, match, adv, flush, alloc, req_valid, gnt, rsp_hit;
    logic [LA_W-1:0]   head_line [NWAYS];
    logic [DATA_W-1:0] head_data [NWAYS];
    logic [LA_W-1:0]   req_line  [NWAYS];
    logic [SLOT_W-1:0] req_slot  [NWAYS];
    logic [WAY_W-1:0]  win, alloc_way, victim, pick, touch_idx;
    logic              any_match, hit, alloc_en, touch;
    logic [WAY_W-1:0]  rsp_way;
    logic [SLOT_W-1:0] rsp_slot;

    assign miss_line = miss_addr[ADDR_W-1:OFF_W];
    assign rsp_way   = mrsp_tag[TAG_W-1:SLOT_W];
    assign rsp_slot  = mrsp_tag[SLOT_W-1:0];

    // Lowest matching way serves; lowest empty way is preferred on takeover.
    always_comb begin
        win       = '0;
        alloc_way = victim;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (match[i])   win       = WAY_W'(i);
            if (!active[i]) alloc_way = WAY_W'(i);
        end
        any_match = |match;
        hit       = any_match && head_ready[win];
        alloc_en  = miss_valid && !any_match;
        touch     = hit || alloc_en;
        touch_idx = hit ? win : alloc_way;
    end

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        assign match[g]   = miss_valid && active[g] && (head_line[g] == miss_line);
        assign adv[g]     = hit && (win == WAY_W'(g));
        assign flush[g]   = match[g] && (win != WAY_W'(g));
        assign alloc[g]   = alloc_en && (alloc_way == WAY_W'(g));
        assign rsp_hit[g] = mrsp_valid && (rsp_way == WAY_W'(g));

        seqbuf_way #(
            .LA_W   (LA_W),
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .SLOT_W (SLOT_W)
        ) u_way (
            .clk          (clk),
            .rst          (rst),
            .alloc_i      (alloc[g]),
            .alloc_line_i (miss_line + 1'b1),
            .flush_i      (flush[g]),
            .adv_i        (adv[g]),
            .grant_i      (gnt[g]),
            .rsp_valid_i  (rsp_hit[g]),
            .rsp_slot_i   (rsp_slot),
            .rsp_data_i   (mrsp_data),
            .active_o     (active[g]),
            .head_line_o  (head_line[g]),
            .head_ready_o (head_ready[g]),
            .head_data_o  (head_data[g]),
            .req_valid_o  (req_valid[g]),
            .req_line_o   (req_line[g]),
            .req_slot_o   (req_slot[g])
        );
    end

    seqbuf_lru #(.N(NWAYS), .IDX_W(WAY_W)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .touch_i     (touch),
        .touch_idx_i (touch_idx),
        .victim_o    (victim)
    );

    seqbuf_rr_arb #(.N(NWAYS), .IDX_W(WAY_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_valid),
        .accept_i (mreq_ready),
        .gnt_o    (gnt),
        .pick_o   (pick),
        .any_o    (mreq_valid)
    );

    assign mreq_addr = {req_line[pick], {OFF_W{1'b0}}};
    assign mreq_tag  = {pick, req_slot[pick]};

    always_ff @(posedge clk) begin
        if (rst) begin
            supply_valid <= 1'b0;
            supply_data  <= '0;
        end else begin
            supply_valid <= hit;
            if (hit) supply_data <= head_data[win];
        end
    end

endmodule

// File: rtl/seqbuf_multiway_chk.sv
module seqbuf_multiway_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int NWAYS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic              supply_valid,
    input logic              mreq_valid,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic [NWAYS-1:0]  match,
    input logic [NWAYS-1:0]  head_ready,
    input logic [NWAYS-1:0]  gnt,
    input logic [NWAYS-1:0]  adv
);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!supply_valid && !mreq_valid));

    a_r2_supply_needs_miss: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> !supply_valid);

    a_r6_no_supply_unready: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && ((match & head_ready) == '0)) |=> !supply_valid);

    a_r7_single_advance: assert property (@(posedge clk) disable iff (rst)
        $onehot0(adv));

    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    a_r8_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !mreq_valid |-> (gnt == '0));

    a_r8_line_aligned: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> (mreq_addr[OFF_W-1:0] == '0));

endmodule

bind seqbuf_multiway seqbuf_multiway_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .NWAYS  (NWAYS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .miss_valid   (miss_valid),
    .supply_valid (supply_valid),
    .mreq_valid   (mreq_valid),
    .mreq_addr    (mreq_addr),
    .match        (match),
    .head_ready   (head_ready),
    .gnt          (gnt),
    .adv          (adv)
);

// File: tb/tb_seqbuf_multiway.sv
module tb_seqbuf_multiway;

    localparam int LAT = 5;
    localparam int NV  = 30;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         miss_valid = 1'b0;
    logic [31:0]  miss_addr = '0;
    logic         supply_valid;
    logic [127:0] supply_data;
    logic         mreq_valid;
    logic         mreq_ready = 1'b1;
    logic [31:0]  mreq_addr;
    logic [3:0]   mreq_tag;
    logic         mrsp_valid;
    logic [3:0]   mrsp_tag;
    logic [127:0] mrsp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    seqbuf_multiway dut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .supply_valid(supply_valid), .supply_data(supply_data),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
        .mreq_tag(mreq_tag), .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag),
        .mrsp_data(mrsp_data)
    );

    function automatic logic [127:0] pat(input logic [27:0] l);
        return {4'h0, l ^ 28'h5A5A5A5, 4'h1, l, 4'h2, ~l, 4'h3, l + 28'h1234567};
    endfunction

    // Next-level memory: fixed latency, in order.
    logic        pv [LAT];
    logic [3:0]  pt [LAT];
    logic [27:0] pl [LAT];
    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LAT; s++) pv[s] <= 1'b0;
        end else begin
            pv[0] <= mreq_valid && mreq_ready;
            pt[0] <= mreq_tag;
            pl[0] <= mreq_addr[31:4];
            for (int s = 1; s < LAT; s++) begin
                pv[s] <= pv[s-1];
                pt[s] <= pt[s-1];
                pl[s] <= pl[s-1];
            end
        end
    end
    assign mrsp_valid = pv[LAT-1];
    assign mrsp_tag   = pt[LAT-1];
    assign mrsp_data  = pat(pl[LAT-1]);

    // Request tag monitor
    bit         mon_en = 1'b0;
    int         mon_n  = 0;
    logic [3:0] mon_tag [8];
    always @(negedge clk) begin
        if (mon_en && mreq_valid && mreq_ready && mon_n < 8) begin
            mon_tag[mon_n] = mreq_tag;
            mon_n++;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        miss_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue_miss(input logic [31:0] a, output logic sv, output logic [127:0] sd);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        @(negedge clk);
        miss_valid = 1'b0;
        sv = supply_valid;
        sd = supply_data;
    endtask

    // {miss byte address, expected supply}
    localparam logic [32:0] VEC [NV] = '{
        {32'h0000_1000, 1'b0},  // way0 <- 0x101..
        {32'h0000_1010, 1'b1},  // hit
        {32'h0000_2000, 1'b0},  // way1
        {32'h0000_3000, 1'b0},  // way2
        {32'h0000_4000, 1'b0},  // way3
        {32'h0000_2010, 1'b1},
        {32'h0000_1020, 1'b1},  // R5: least recent is now way2
        {32'h0000_5000, 1'b0},  // replaces way2
        {32'h0000_3010, 1'b0},  // stream gone, takes way3
        {32'h0000_1038, 1'b1},  // nonzero offset
        {32'h0000_2020, 1'b1},
        {32'h0000_5010, 1'b1},
        {32'h0000_3020, 1'b1},
        {32'h0000_4010, 1'b0},  // takes way0
        {32'h0000_1040, 1'b0},  // takes way1
        {32'h0000_2030, 1'b0},  // takes way2
        {32'h0000_5020, 1'b0},  // takes way3
        {32'h0000_4020, 1'b1},
        {32'h0000_1050, 1'b1},
        {32'h0000_7000, 1'b0},  // R3 long walk starts
        {32'h0000_7010, 1'b1},
        {32'h0000_7020, 1'b1},
        {32'h0000_7030, 1'b1},
        {32'h0000_7040, 1'b1},
        {32'h0000_7050, 1'b1},
        {32'h0000_7060, 1'b1},
        {32'h0000_7070, 1'b1},
        {32'h0000_7080, 1'b1},
        {32'h0000_7090, 1'b1},
        {32'h0000_70A0, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic         sv;
        logic [127:0] sd;

        // R1: reset state
        do_reset();
        check("R1 supply after reset", {127'd0, supply_valid}, 128'd0);
        check("R1 request after reset", {127'd0, mreq_valid}, 128'd0);
        idle(5);
        check("R1 request while idle", {127'd0, mreq_valid}, 128'd0);

        // Table walk: R2 hits, R4/R5 takeovers, R3 long walk
        for (int i = 0; i < NV; i++) begin
            issue_miss(VEC[i][32:1], sv, sd);
            if (VEC[i][0]) begin
                check($sformatf("R2 hit vec %0d", i), {127'd0, sv}, 128'd1);
                check($sformatf("R3 data vec %0d", i), sd, pat(VEC[i][32:5]));
            end else begin
                check($sformatf("R4 no supply vec %0d", i), {127'd0, sv}, 128'd0);
            end
            idle(24);
        end

        // R8: rotating grants and tag layout with four back-to-back misses
        do_reset();
        mon_n  = 0;
        mon_en = 1'b1;
        @(negedge clk); miss_valid = 1'b1; miss_addr = 32'h0000_A000;
        @(negedge clk); miss_addr = 32'h0000_B000;
        @(negedge clk); miss_addr = 32'h0000_C000;
        @(negedge clk); miss_addr = 32'h0000_D000;
        @(negedge clk); miss_valid = 1'b0;
        idle(20);
        mon_en = 1'b0;
        check("R8 request count", 128'(mon_n), 128'd8);
        for (int i = 0; i < 8; i++)
            check($sformatf("R8 tag %0d", i), {124'd0, mon_tag[i]},
                  {124'd0, 2'(i % 4), 2'(i / 4)});

        // R9: takeover while a fetch is in flight
        do_reset();
        @(negedge clk); miss_valid = 1'b1; miss_addr = 32'h0000_A000;
        @(negedge clk); miss_addr = 32'h0000_B000;
        @(negedge clk); miss_addr = 32'h0000_C000;
        @(negedge clk); miss_addr = 32'h0000_D000;
        @(negedge clk); miss_addr = 32'h0000_E000;
        @(negedge clk); miss_valid = 1'b0;
        idle(40);
        issue_miss(32'h0000_E010, sv, sd);
        check("R9 new stream hit", {127'd0, sv}, 128'd1);
        check("R9 new stream data", sd, pat(28'hE01));
        idle(10);
        issue_miss(32'h0000_A010, sv, sd);
        check("R4 displaced stream", {127'd0, sv}, 128'd0);

        // R6: head matched before its data returned
        do_reset();
        @(negedge clk); miss_valid = 1'b1; miss_addr = 32'h0000_8000;
        @(negedge clk); miss_addr = 32'h0000_8010;
        @(negedge clk); miss_valid = 1'b0;
        check("R6 pending head", {127'd0, supply_valid}, 128'd0);
        idle(30);
        issue_miss(32'h0000_8010, sv, sd);
        check("R6 later hit", {127'd0, sv}, 128'd1);
        check("R6 later data", sd, pat(28'h801));

        // R7: two ways with the same head
        do_reset();
        issue_miss(32'h0000_9000, sv, sd); idle(30);
        issue_miss(32'h0000_8FF0, sv, sd); idle(30);
        issue_miss(32'h0000_9000, sv, sd);
        check("R7 first hit data", sd, pat(28'h900)); idle(30);
        issue_miss(32'h0000_9010, sv, sd);
        check("R7 shared head hit", {127'd0, sv}, 128'd1);
        check("R7 shared head data", sd, pat(28'h901)); idle(30);
        issue_miss(32'h0000_9020, sv, sd);
        check("R7 winner advanced", sd, pat(28'h902)); idle(30);
        issue_miss(32'h0000_9010, sv, sd);
        check("R7 loser emptied", {127'd0, sv}, 128'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule